// File: doc/BRIEF.md
# Blit Parameter Staging and Launch

This block is the parameter front end of a 2D block-transfer engine. Software writes one byte at a time into a queued copy of every parameter. The queued copy holds three 32-bit addresses (pattern, source, destination), three 16-bit line pitches, two 16-bit extents and three control bytes. The pixel engine never sees the queued copy. It reads a separate active copy, which changes only when a launch is accepted.

A write to the most significant byte of the destination address is the launch trigger. If the engine is idle, the active copy is loaded from the queued copy in a single cycle, and that copy includes the byte just written. A busy flag is raised at the same time. If the routing byte has none of the bits in mask 0x37 set, a one-cycle start pulse is issued. Otherwise the block raises a flag saying it is waiting for CPU-supplied data.

The engine ends an operation by pulsing `eng_done`. This clears the busy flag and the waiting flag.

Top module: `blit_param_stage`

## Requirements
- R1: After reset, every active output is zero, and `busy`, `start_pulse` and `cpu_wait` are 0.
- R2: Each 32-bit address register is written least significant byte first at ascending offsets: pattern at 0x80..0x83, source at 0x84..0x87, destination at 0xA0..0xA3.
- R3: Each 16-bit register takes its low byte at the even offset and its high byte at the next offset: pattern pitch 0x88/0x89, source pitch 0x8A/0x8B, destination pitch 0x8C/0x8D, X extent 0x98/0x99, Y extent 0x9A/0x9B.
- R4: A byte write replaces only its own byte lane. The other lanes of the same register keep their values.
- R5: The routing byte is at 0x9C and the pattern wrap byte is at 0x90, both stored unchanged. The source wrap byte is at 0x92 and is stored ANDed with 0x77.
- R6: Writes to the queued set have no effect on the active outputs until a launch is accepted.
- R7: A write to 0xA3 while `busy` is 0 is accepted as a launch. One cycle later, every active output equals the queued value including that byte, and `busy` is 1.
- R8: On an accepted launch, if routing AND 0x37 is zero, `start_pulse` is high for exactly one cycle and `cpu_wait` stays 0. Otherwise `cpu_wait` becomes 1 and no start pulse is issued.
- R9: `eng_done` clears `busy` and `cpu_wait` one cycle later. `eng_done` while idle has no effect.
- R10: While `busy` is 1, writes (including to 0xA3) still update the queued set but leave the active outputs unchanged and produce no start pulse.
- R11: If a write to 0xA3 and `eng_done` fall in the same cycle while busy, the launch is refused, `busy` falls, and the byte is kept in the queued set for the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 8 | Write data |
| eng_done | input | 1 | Engine finished the current operation |
| act_pat_addr | output | 32 | Active pattern address |
| act_src_addr | output | 32 | Active source address |
| act_dst_addr | output | 32 | Active destination address |
| act_pat_pitch | output | 16 | Active pattern line pitch |
| act_src_pitch | output | 16 | Active source line pitch |
| act_dst_pitch | output | 16 | Active destination line pitch |
| act_xcnt | output | 16 | Active X extent |
| act_ycnt | output | 16 | Active Y extent |
| act_route | output | 8 | Active routing byte |
| act_pat_wrap | output | 8 | Active pattern wrap byte |
| act_src_wrap | output | 8 | Active source wrap byte (masked) |
| start_pulse | output | 1 | One-cycle engine start |
| busy | output | 1 | Operation in progress |
| cpu_wait | output | 1 | Launched, waiting for CPU data |

## Verification
Two functions can fall in the same cycle: the engine's completion and a launch write to 0xA3. The bench provokes this by raising `eng_done` in the very cycle that writes 0xA3 during a busy operation. It judges the outcome by three things. `busy` must fall. The active outputs and the start pulse must stay untouched. A later launch must then carry the byte that was written, so that outcome is compared against the bench's own model of the queued set.

// File: rtl/blit_param_stage.sv
module blit_param_stage (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        eng_done,
  output logic [31:0] act_pat_addr,
  output logic [31:0] act_src_addr,
  output logic [31:0] act_dst_addr,
  output logic [15:0] act_pat_pitch,
  output logic [15:0] act_src_pitch,
  output logic [15:0] act_dst_pitch,
  output logic [15:0] act_xcnt,
  output logic [15:0] act_ycnt,
  output logic [7:0]  act_route,
  output logic [7:0]  act_pat_wrap,
  output logic [7:0]  act_src_wrap,
  output logic        start_pulse,
  output logic        busy,
  output logic        cpu_wait
);

  localparam logic [7:0] LAUNCH_OFS = 8'hA3;
  localparam logic [7:0] AUTO_MASK  = 8'h37;
  localparam logic [7:0] SWRAP_MASK = 8'h77;

  logic [31:0] q_pat, q_src, q_dst, n_pat, n_src, n_dst;
  logic [15:0] q_ppit, q_spit, q_dpit, q_xc, q_yc;
  logic [15:0] n_ppit, n_spit, n_dpit, n_xc, n_yc;
  logic [7:0]  q_route, q_pwrap, q_swrap, n_route, n_pwrap, n_swrap;
  logic        commit, auto_go;

  always_comb begin
    n_pat = q_pat;  n_src = q_src;  n_dst = q_dst;
    n_ppit = q_ppit; n_spit = q_spit; n_dpit = q_dpit;
    n_xc = q_xc; n_yc = q_yc;
    n_route = q_route; n_pwrap = q_pwrap; n_swrap = q_swrap;
    if (wr_en) begin
      case (wr_addr)
        8'h80: n_pat[7:0]   = wr_data;
        8'h81: n_pat[15:8]  = wr_data;
        8'h82: n_pat[23:16] = wr_data;
        8'h83: n_pat[31:24] = wr_data;
        8'h84: n_src[7:0]   = wr_data;
        8'h85: n_src[15:8]  = wr_data;
        8'h86: n_src[23:16] = wr_data;
        8'h87: n_src[31:24] = wr_data;
        8'h88: n_ppit[7:0]  = wr_data;
        8'h89: n_ppit[15:8] = wr_data;
        8'h8A: n_spit[7:0]  = wr_data;
        8'h8B: n_spit[15:8] = wr_data;
        8'h8C: n_dpit[7:0]  = wr_data;
        8'h8D: n_dpit[15:8] = wr_data;
        8'h90: n_pwrap      = wr_data;
        8'h92: n_swrap      = wr_data & SWRAP_MASK;
        8'h98: n_xc[7:0]    = wr_data;
        8'h99: n_xc[15:8]   = wr_data;
        8'h9A: n_yc[7:0]    = wr_data;
        8'h9B: n_yc[15:8]   = wr_data;
        8'h9C: n_route      = wr_data;
        8'hA0: n_dst[7:0]   = wr_data;
        8'hA1: n_dst[15:8]  = wr_data;
        8'hA2: n_dst[23:16] = wr_data;
        8'hA3: n_dst[31:24] = wr_data;
        default: ;
      endcase
    end
  end

  assign commit  = wr_en && (wr_addr == LAUNCH_OFS) && !busy;
  assign auto_go = (n_route & AUTO_MASK) == 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_pat <= '0; q_src <= '0; q_dst <= '0;
      q_ppit <= '0; q_spit <= '0; q_dpit <= '0;
      q_xc <= '0; q_yc <= '0;
      q_route <= '0; q_pwrap <= '0; q_swrap <= '0;
    end else begin
      q_pat <= n_pat; q_src <= n_src; q_dst <= n_dst;
      q_ppit <= n_ppit; q_spit <= n_spit; q_dpit <= n_dpit;
      q_xc <= n_xc; q_yc <= n_yc;
      q_route <= n_route; q_pwrap <= n_pwrap; q_swrap <= n_swrap;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_pat_addr <= '0; act_src_addr <= '0; act_dst_addr <= '0;
      act_pat_pitch <= '0; act_src_pitch <= '0; act_dst_pitch <= '0;
      act_xcnt <= '0; act_ycnt <= '0;
      act_route <= '0; act_pat_wrap <= '0; act_src_wrap <= '0;
    end else if (commit) begin
      act_pat_addr <= n_pat; act_src_addr <= n_src; act_dst_addr <= n_dst;
      act_pat_pitch <= n_ppit; act_src_pitch <= n_spit; act_dst_pitch <= n_dpit;
      act_xcnt <= n_xc; act_ycnt <= n_yc;
      act_route <= n_route; act_pat_wrap <= n_pwrap; act_src_wrap <= n_swrap;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cpu_wait    <= 1'b0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= commit && auto_go;
      if (commit) begin
        busy     <= 1'b1;
        cpu_wait <= !auto_go;
      end else if (eng_done) begin
        busy     <= 1'b0;
        cpu_wait <= 1'b0;
      end
    end
  end

  // R8
  start_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (busy && !cpu_wait));

  // R8
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  // R10
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(act_dst_addr) && $stable(act_pat_addr) && $stable(act_src_addr)
              && $stable(act_route) && $stable(act_xcnt) && $stable(act_ycnt)));

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done) |=> (!busy && !cpu_wait));

  // R7
  launch_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (start_pulse != cpu_wait));

  // R5
  swrap_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_src_wrap & 8'h88) == 8'h00);

endmodule

// File: tb/blit_param_stage_tb.sv
`timescale 1ns/1ps
module blit_param_stage_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, eng_done = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic [31:0] act_pat_addr, act_src_addr, act_dst_addr;
  logic [15:0] act_pat_pitch, act_src_pitch, act_dst_pitch, act_xcnt, act_ycnt;
  logic [7:0] act_route, act_pat_wrap, act_src_wrap;
  logic start_pulse, busy, cpu_wait;

  always #4 clk = ~clk;

  blit_param_stage dut_i (.*);

  wire [199:0] act_v = {act_pat_addr, act_src_addr, act_dst_addr, act_pat_pitch,
                        act_src_pitch, act_dst_pitch, act_xcnt, act_ycnt,
                        act_route, act_pat_wrap, act_src_wrap};

  typedef struct { logic [199:0] v; logic st; logic wt; } rec_t;
  rec_t exp_q[$];
  logic [7:0] mb [0:255];
  logic [199:0] last_act = '0;
  logic mbusy = 1'b0, pbusy = 1'b0, done_flag = 1'b0;
  int checks = 0, fails = 0;

  function automatic logic [199:0] model_v();
    return {mb[8'h83], mb[8'h82], mb[8'h81], mb[8'h80],
            mb[8'h87], mb[8'h86], mb[8'h85], mb[8'h84],
            mb[8'hA3], mb[8'hA2], mb[8'hA1], mb[8'hA0],
            mb[8'h89], mb[8'h88], mb[8'h8B], mb[8'h8A], mb[8'h8D], mb[8'h8C],
            mb[8'h99], mb[8'h98], mb[8'h9B], mb[8'h9A],
            mb[8'h9C], mb[8'h90], mb[8'h92]};
  endfunction

  task automatic chk(string req, logic [199:0] got, logic [199:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, logic with_done = 1'b0);
    rec_t r;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; eng_done = with_done;
    mb[a] = (a == 8'h92) ? (d & 8'h77) : d;
    if (a == 8'hA3 && !mbusy) begin
      r.v  = model_v();
      r.st = ((mb[8'h9C] & 8'h37) == 8'h00);
      r.wt = !r.st;
      exp_q.push_back(r);
      mbusy = 1'b1;
    end else if (with_done) mbusy = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; eng_done = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    eng_done = 1'b1; mbusy = 1'b0;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !pbusy) begin
        rec_t r;
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R7 actual=unexpected launch expected=no launch");
        end else begin
          r = exp_q.pop_front();
          chk("R7 active set", act_v, r.v);
          chk("R8 start", {199'b0, start_pulse}, {199'b0, r.st});
          chk("R8 cpu_wait", {199'b0, cpu_wait}, {199'b0, r.wt});
          last_act = r.v;
        end
      end else if (start_pulse) begin
        checks++; fails++;
        $display("FAIL R10 actual=start expected=no start");
      end
      pbusy = busy;
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mb[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 active", act_v, '0);
    chk("R1 flags", {197'b0, busy, start_pulse, cpu_wait}, '0);

    // R2 R3 R5 fill queued set
    wr(8'h80, 8'h11); wr(8'h81, 8'h22); wr(8'h82, 8'h33); wr(8'h83, 8'h44);
    wr(8'h84, 8'h55); wr(8'h85, 8'h66); wr(8'h86, 8'h77); wr(8'h87, 8'h88);
    wr(8'h88, 8'h01); wr(8'h89, 8'h02); wr(8'h8A, 8'h03); wr(8'h8B, 8'h04);
    wr(8'h8C, 8'h05); wr(8'h8D, 8'h06); wr(8'h98, 8'h07); wr(8'h99, 8'h08);
    wr(8'h9A, 8'h09); wr(8'h9B, 8'h0A); wr(8'h90, 8'hC3); wr(8'h92, 8'hFF);
    wr(8'h9C, 8'h00); wr(8'hA0, 8'hA5); wr(8'hA1, 8'hB6); wr(8'hA2, 8'hC7);
    // R6 nothing visible yet
    chk("R6 no commit", act_v, '0);
    wr(8'hA3, 8'hD8);
    // R8 pulse is one cycle wide
    @(negedge clk);
    chk("R8 pulse width", {199'b0, start_pulse}, '0);
    chk("R5 src wrap mask", {192'b0, act_src_wrap}, {192'b0, 8'h77});

    // R10 writes while busy
    wr(8'h81, 8'hEE); wr(8'hA3, 8'h9F);
    chk("R10 active held", act_v, last_act);
    chk("R10 busy held", {199'b0, busy}, {199'b0, 1'b1});
    done_pulse();
    // R9 done clears
    chk("R9 busy clear", {198'b0, busy, cpu_wait}, '0);

    // R4 single lane update, routing 0x08 still auto-starts
    wr(8'h85, 8'h5A); wr(8'h9C, 8'h08); wr(8'hA3, 8'h12);
    chk("R4 lane only", {168'b0, act_src_addr}, {168'b0, 32'h88775A55});
    done_pulse();

    // R8 CPU-fed launch
    wr(8'h9C, 8'h01); wr(8'hA3, 8'h34);
    chk("R8 waiting", {198'b0, start_pulse, cpu_wait}, {198'b0, 2'b01});
    done_pulse();
    chk("R9 wait clear", {198'b0, busy, cpu_wait}, '0);

    // R9 done while idle
    done_pulse();
    chk("R9 idle done", {199'b0, busy}, '0);

    // R11 launch write coincident with done
    wr(8'h9C, 8'h00); wr(8'hA3, 8'h56);
    wr(8'hA3, 8'h78, 1'b1);
    chk("R11 busy fell", {199'b0, busy}, '0);
    chk("R11 active held", act_v, last_act);
    wr(8'h90, 8'h3C);
    wr(8'hA3, 8'h78);
    chk("R11 byte kept", {192'b0, act_dst_addr[31:24]}, {192'b0, 8'h78});
    done_pulse();

    repeat (3) @(negedge clk);
    chk("R7 queue drained", {168'b0, 32'(exp_q.size())}, '0);
    finish_run();
  end
endmodule